// File: doc/BRIEF.md
# One-Shot Pulse Train Output Driver

This block drives a vector of outputs in a design clock domain. Each output bit is set to one of three behaviours: held low, held high, or a 16-step pattern played once at design-clock speed. A loader in a separate control clock domain writes a mode and a 16-bit pattern into staging registers, one output bit per write, and then issues a commit. The commit crosses into the design domain through a toggle handshake. There the whole staged configuration is captured in one cycle, and every bit starts its new behaviour in that same cycle.

While a commit is in flight, the loader sees a busy flag. The flag guarantees that the staging registers are not disturbed before the design domain has captured them. A commit that reaches the design domain while a pattern is still playing waits until the running pattern has shown all 16 values. A parameter selects the falling edge of the design clock instead of the rising edge.

A second vector of outputs is a plain register in the control clock domain. It is loaded directly by the loader, with no design-clock involvement.

Top module: `ptrain_out`

## Requirements
- R1: While rst_ni is low, and after its release until the first commit or load, sync_o and async_o are all zero and busy_o is low.
- R2: A committed mode code 0 drives the bit low and mode code 1 drives it high. The bit takes the new level in the same design cycle in which pattern bits start.
- R3: Mode codes 2 and 3 both select pattern playback. Pattern bit 0 appears in the first design cycle in which the committed configuration takes effect, followed by bits 1 through 15 on the next 15 cycles, with no gap.
- R4: After its 16th value, a pattern bit holds pattern bit 15 until a later commit takes effect. The pattern never repeats by itself.
- R5: An accepted commit raises busy_o on the next control clock edge. busy_o falls once the design domain has captured the configuration. The new values appear within 12 design cycles of the commit being sampled.
- R6: A write (ld_we_i) or a commit (commit_i) presented while busy_o is high is ignored. The staged configuration stays as it was.
- R7: A commit that reaches the design domain while a pattern is playing does not take effect before the cycle after that pattern's 16th value.
- R8: With INVERT_CLK set, sync_o changes only on falling design-clock edges. Otherwise it changes only on rising edges. Both settings produce the same output sequence.
- R9: When async_we_i is high on a rising control clock edge, async_o takes async_d_i. Otherwise async_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk_i | input | 1 | Control (loader) clock |
| dsn_clk_i | input | 1 | Design clock for the synchronous outputs |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| ld_we_i | input | 1 | Staging write strobe, control domain |
| ld_idx_i | input | IDX_W | Output bit selected by the write |
| ld_mode_i | input | 2 | Mode code: 0 low, 1 high, 2 or 3 pattern |
| ld_pat_i | input | 16 | Pattern, bit 0 played first |
| commit_i | input | 1 | Transfer the staged configuration to the outputs |
| busy_o | output | 1 | Commit in flight; writes and commits are ignored |
| sync_o | output | N_OUT | Design-domain outputs |
| async_we_i | input | 1 | Load strobe for async_o |
| async_d_i | input | N_ASYNC | Value for async_o |
| async_o | output | N_ASYNC | Control-domain static outputs |

## Verification
Two functions can land in the same design cycle: the last step of a running pattern and the arrival of a fresh commit. The bench provokes this by committing one configuration and, as soon as busy_o drops, rewriting one bit and committing again. This places the second commit in the design domain while the first pattern still has many steps left. The sampled output history is then judged against a model that searches for both start cycles. The match must show all 16 values of the first pattern, in order, before any value of the second configuration.

// File: rtl/ptrain_pkg.sv
package ptrain_pkg;
  localparam int unsigned TRAIN_LEN = 16;
  localparam int unsigned MODE_W    = 2;

  typedef logic [TRAIN_LEN-1:0] pattern_t;
  typedef logic [MODE_W-1:0]    mode_t;

  // mode[1] selects playback, otherwise mode[0] is the static level
  localparam mode_t MODE_LOW  = 2'd0;
  localparam mode_t MODE_HIGH = 2'd1;
  localparam mode_t MODE_PLAY = 2'd2;
endpackage

// File: rtl/ptrain_sync.sv
module ptrain_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/ptrain_stage.sv
module ptrain_stage import ptrain_pkg::*; #(
  parameter int unsigned N_OUT       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W      = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  mode_t                  mode_i,
  input  pattern_t               pat_i,
  input  logic                   commit_i,
  input  logic                   ack_i,
  output logic                   busy_o,
  output logic                   req_o,
  output mode_t    [N_OUT-1:0]   mode_o,
  output pattern_t [N_OUT-1:0]   pat_o
);
  logic ack_s, req_q;
  mode_t    [N_OUT-1:0] mode_q;
  pattern_t [N_OUT-1:0] pat_q;

  ptrain_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ack_i), .q_o(ack_s)
  );

  assign busy_o = req_q ^ ack_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  req_q <= 1'b0;
    else if (commit_i && !busy_o) req_q <= ~req_q;
  end

  for (genvar b = 0; b < N_OUT; b++) begin : g_slot
    logic hit;
    assign hit = we_i && !busy_o && (idx_i == IDX_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mode_q[b] <= MODE_LOW;
        pat_q[b]  <= '0;
      end else if (hit) begin
        mode_q[b] <= mode_i;
        pat_q[b]  <= pat_i;
      end
    end
  end

  assign req_o  = req_q;
  assign mode_o = mode_q;
  assign pat_o  = pat_q;

  a_r6_stage_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(mode_q) && $stable(pat_q)));

  a_r5_busy_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !busy_o) |=> busy_o);
endmodule

// File: rtl/ptrain_player.sv
module ptrain_player import ptrain_pkg::*; #(
  parameter int unsigned N_OUT       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  mode_t    [N_OUT-1:0] mode_i,
  input  pattern_t [N_OUT-1:0] pat_i,
  output logic                 ack_o,
  output logic [N_OUT-1:0]     sync_o
);
  localparam int unsigned CNT_W = $clog2(TRAIN_LEN);

  logic             req_s, seen_q, pending, apply, any_play;
  logic [CNT_W-1:0] left_q;
  logic [N_OUT-1:0] out_q, play_q;

  ptrain_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(req_i), .q_o(req_s)
  );

  assign pending = req_s ^ seen_q;
  assign apply   = pending && (left_q == '0);

  always_comb begin
    any_play = 1'b0;
    for (int b = 0; b < N_OUT; b++) any_play |= mode_i[b][1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      left_q <= '0;
    end else if (apply) begin
      seen_q <= req_s;
      left_q <= any_play ? CNT_W'(TRAIN_LEN - 1) : '0;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  for (genvar b = 0; b < N_OUT; b++) begin : g_lane
    pattern_t shf_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        out_q[b]  <= 1'b0;
        play_q[b] <= 1'b0;
        shf_q     <= '0;
      end else if (apply) begin
        play_q[b] <= mode_i[b][1];
        if (mode_i[b][1]) begin
          out_q[b] <= pat_i[b][0];
          shf_q    <= pat_i[b] >> 1;
        end else begin
          out_q[b] <= mode_i[b][0];
        end
      end else if ((left_q != '0) && play_q[b]) begin
        out_q[b] <= shf_q[0];
        shf_q    <= shf_q >> 1;
      end
    end
  end

  assign ack_o  = seen_q;
  assign sync_o = out_q;

  a_r7_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_q != '0) |=> (left_q == $past(left_q) - 1'b1));

  a_r4_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((left_q == '0) && !pending) |=> $stable(sync_o));
endmodule

// File: rtl/ptrain_out.sv
module ptrain_out import ptrain_pkg::*; #(
  parameter int unsigned N_OUT       = 8,
  parameter int unsigned N_ASYNC     = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          INVERT_CLK  = 1'b0,
  localparam int unsigned IDX_W      = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic                 ctl_clk_i,
  input  logic                 dsn_clk_i,
  input  logic                 rst_ni,
  input  logic                 ld_we_i,
  input  logic [IDX_W-1:0]     ld_idx_i,
  input  logic [MODE_W-1:0]    ld_mode_i,
  input  logic [TRAIN_LEN-1:0] ld_pat_i,
  input  logic                 commit_i,
  output logic                 busy_o,
  output logic [N_OUT-1:0]     sync_o,
  input  logic                 async_we_i,
  input  logic [N_ASYNC-1:0]   async_d_i,
  output logic [N_ASYNC-1:0]   async_o
);
  logic dclk, req, ack;
  mode_t    [N_OUT-1:0] st_mode;
  pattern_t [N_OUT-1:0] st_pat;
  logic [N_ASYNC-1:0]   async_q;

  if (INVERT_CLK) begin : g_clk_inv
    assign dclk = ~dsn_clk_i;
  end else begin : g_clk_dir
    assign dclk = dsn_clk_i;
  end

  ptrain_stage #(.N_OUT(N_OUT), .SYNC_STAGES(SYNC_STAGES)) u_stage (
    .clk_i(ctl_clk_i), .rst_ni(rst_ni), .we_i(ld_we_i), .idx_i(ld_idx_i),
    .mode_i(ld_mode_i), .pat_i(ld_pat_i), .commit_i(commit_i), .ack_i(ack),
    .busy_o(busy_o), .req_o(req), .mode_o(st_mode), .pat_o(st_pat)
  );

  ptrain_player #(.N_OUT(N_OUT), .SYNC_STAGES(SYNC_STAGES)) u_player (
    .clk_i(dclk), .rst_ni(rst_ni), .req_i(req), .mode_i(st_mode),
    .pat_i(st_pat), .ack_o(ack), .sync_o(sync_o)
  );

  always_ff @(posedge ctl_clk_i or negedge rst_ni) begin
    if (!rst_ni)         async_q <= '0;
    else if (async_we_i) async_q <= async_d_i;
  end

  assign async_o = async_q;

  a_r9_async_hold: assert property (@(posedge ctl_clk_i) disable iff (!rst_ni)
    !async_we_i |=> $stable(async_o));
endmodule

// File: tb/ptrain_out_test.sv
module ptrain_out_test;
  localparam int HLEN = 100;

  logic ctl_clk = 1'b0, dsn_clk = 1'b0, rst_ni = 1'b0;
  logic ld_we = 1'b0, commit = 1'b0, async_we = 1'b0;
  logic [2:0]  ld_idx = '0;
  logic [1:0]  ld_mode = '0;
  logic [15:0] ld_pat = '0;
  logic [7:0]  async_d = '0;
  logic        busy, busy_n;
  logic [7:0]  sync_o, sync_n, async_o, async_n;

  always #5 dsn_clk = ~dsn_clk;
  always #7 ctl_clk = ~ctl_clk;

  ptrain_out uut (
    .ctl_clk_i(ctl_clk), .dsn_clk_i(dsn_clk), .rst_ni(rst_ni), .ld_we_i(ld_we),
    .ld_idx_i(ld_idx), .ld_mode_i(ld_mode), .ld_pat_i(ld_pat), .commit_i(commit),
    .busy_o(busy), .sync_o(sync_o), .async_we_i(async_we), .async_d_i(async_d),
    .async_o(async_o));

  ptrain_out #(.INVERT_CLK(1'b1)) uut_neg (
    .ctl_clk_i(ctl_clk), .dsn_clk_i(dsn_clk), .rst_ni(rst_ni), .ld_we_i(ld_we),
    .ld_idx_i(ld_idx), .ld_mode_i(ld_mode), .ld_pat_i(ld_pat), .commit_i(commit),
    .busy_o(busy_n), .sync_o(sync_n), .async_we_i(async_we), .async_d_i(async_d),
    .async_o(async_n));

  int n_chk = 0, n_err = 0;
  logic [1:0]  bm_mode [8];
  logic [15:0] bm_pat  [8];
  logic [1:0]  ma [8], mb [8];
  logic [15:0] pa [8], pb [8];
  logic [7:0]  old_v;
  logic [7:0]  hist [HLEN];
  int  rec_n = 0;
  bit  rec_on = 0, mon_on = 0;
  int  tim_bad = 0, chg_neg = 0;

  always @(negedge dsn_clk) if (rec_on && rec_n < HLEN) begin
    hist[rec_n] = sync_o;
    rec_n++;
  end

  // R8: rising-edge copy changes at t%10==5, inverted copy at t%10==0
  always @(sync_o) if (mon_on && ($time % 10) != 5) tim_bad++;
  always @(sync_n) if (mon_on) begin
    chg_neg++;
    if (($time % 10) != 0) tim_bad++;
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(logic ov, int t, int k, logic [1:0] m, logic [15:0] p);
    int ix;
    if (t < k) return ov;
    if (!m[1]) return m[0];
    ix = t - k;
    if (ix > 15) ix = 15;
    return p[ix];
  endfunction

  function automatic bit fits(int ka, int kb);
    for (int t = 0; t < rec_n; t++)
      for (int b = 0; b < 8; b++) begin
        logic e;
        if (kb >= 0 && t >= kb) e = exp_bit(1'b0, t, kb, mb[b], pb[b]);
        else                    e = exp_bit(old_v[b], t, ka, ma[b], pa[b]);
        if (hist[t][b] !== e) return 1'b0;
      end
    return 1'b1;
  endfunction

  function automatic logic [7:0] final_val();
    logic [7:0] v;
    for (int b = 0; b < 8; b++) v[b] = exp_bit(1'b0, 1000, 0, bm_mode[b], bm_pat[b]);
    return v;
  endfunction

  task automatic stage(int idx, logic [1:0] m, logic [15:0] p, bit upd);
    @(negedge ctl_clk);
    ld_we = 1'b1; ld_idx = 3'(idx); ld_mode = m; ld_pat = p;
    @(negedge ctl_clk);
    ld_we = 1'b0;
    if (upd) begin bm_mode[idx] = m; bm_pat[idx] = p; end
  endtask

  task automatic commit_rec();
    old_v = sync_o;
    for (int b = 0; b < 8; b++) begin ma[b] = bm_mode[b]; pa[b] = bm_pat[b]; end
    @(negedge ctl_clk);
    rec_n = 0; rec_on = 1; commit = 1'b1;
    @(negedge ctl_clk);
    commit = 1'b0;
    check(busy === 1'b1, "R5 busy after commit", busy, 1);
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 1000) begin @(negedge ctl_clk); g++; end
    check(busy === 1'b0, "R5 busy clears", busy, 0);
  endtask

  task automatic wait_rec();
    while (rec_n < HLEN) @(negedge dsn_clk);
    rec_on = 0;
  endtask

  task automatic run_one(string req);
    bit found = 0;
    commit_rec();
    wait_idle();
    wait_rec();
    for (int k = 1; k <= 12 && !found; k++) found = fits(k, -1);
    check(found, req, sync_o, final_val());
    check(sync_o === final_val(), "R4 final hold", sync_o, final_val());
    check(sync_n === sync_o, "R8 inverted copy same result", sync_n, sync_o);
  endtask

  initial begin
    repeat (150000) @(posedge dsn_clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int b = 0; b < 8; b++) begin bm_mode[b] = 2'd0; bm_pat[b] = '0; end
    #23;
    check(sync_o === 8'h00, "R1 sync_o in reset", sync_o, 0);
    check(async_o === 8'h00, "R1 async_o in reset", async_o, 0);
    check(busy === 1'b0, "R1 busy in reset", busy, 0);
    #80 rst_ni = 1'b1;
    mon_on = 1;
    repeat (3) @(negedge ctl_clk);
    check(sync_o === 8'h00 && busy === 1'b0, "R1 after release", {busy, sync_o}, 0);

    // R2 static levels: even bits code 0, odd bits code 1
    for (int b = 0; b < 8; b++) stage(b, 2'(b % 2), 16'hFFFF, 1);
    run_one("R2 static levels");
    check(sync_o === 8'hAA, "R2 level map", sync_o, 8'hAA);

    // R3 directed patterns, code 3 on bit 2
    stage(0, 2'd2, 16'h0001, 1);
    stage(1, 2'd2, 16'h8000, 1);
    stage(2, 2'd3, 16'h00FF, 1);
    stage(3, 2'd2, 16'h5555, 1);
    stage(4, 2'd0, 16'hFFFF, 1);
    stage(5, 2'd1, 16'h0000, 1);
    stage(6, 2'd2, 16'h7FFE, 1);
    stage(7, 2'd3, 16'hC003, 1);
    run_one("R3 directed order");

    // random configurations
    for (int i = 0; i < 10; i++) begin
      for (int b = 0; b < 8; b++) stage(b, 2'($urandom_range(0, 3)), 16'($urandom), 1);
      run_one("R3 random pattern");
    end

    // R7 second commit lands while the first pattern plays
    begin
      bit found = 0;
      for (int b = 0; b < 8; b++) stage(b, 2'd2, 16'($urandom), 1);
      commit_rec();
      wait_idle();
      stage(3, 2'd2, ~bm_pat[3], 1);
      for (int b = 0; b < 8; b++) begin mb[b] = bm_mode[b]; pb[b] = bm_pat[b]; end
      @(negedge ctl_clk); commit = 1'b1;
      @(negedge ctl_clk); commit = 1'b0;
      wait_rec();
      wait_idle();
      for (int ka = 1; ka <= 12 && !found; ka++)
        for (int kb = ka + 16; kb <= ka + 50 && !found; kb++) found = fits(ka, kb);
      check(found, "R7 deferred commit", sync_o, final_val());
    end

    // R6 write and commit while busy are ignored
    for (int b = 0; b < 8; b++) stage(b, 2'd1, 16'h0000, 1);
    commit_rec();
    @(negedge ctl_clk);
    ld_we = 1'b1; ld_idx = 3'd2; ld_mode = 2'd0; ld_pat = '0; commit = 1'b1;
    @(negedge ctl_clk);
    ld_we = 1'b0; commit = 1'b0;
    wait_rec();
    wait_idle();
    repeat (30) @(negedge dsn_clk);
    run_one("R6 config unchanged");
    check(sync_o === 8'hFF, "R6 busy write ignored", sync_o, 8'hFF);

    // R9 async register
    begin
      logic [7:0] v = 8'($urandom);
      @(negedge ctl_clk); async_we = 1'b1; async_d = v;
      @(negedge ctl_clk); async_we = 1'b0; async_d = ~v;
      check(async_o === v, "R9 async load", async_o, v);
      @(negedge ctl_clk);
      check(async_o === v, "R9 async hold", async_o, v);
    end

    check(tim_bad == 0, "R8 edge timing", tim_bad, 0);
    check(chg_neg > 0, "R8 inverted copy active", chg_neg, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule